// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block decides how a small microcontroller is clocked. It combines a control-register value with a one-cycle sleep-instruction strobe and a wake event. The register value holds an idle-enable bit and a 2-bit clock-source select. From these the block picks one of seven operating modes. It drives a one-hot selector toward an external clock multiplexer, two clock-enable lines (CPU and peripherals) and a 3-bit mode code for status.

The select bits choose which source clocks the machine: primary, secondary (low-frequency timer oscillator) or the internal oscillator block. A change of the select bits takes effect only once the requested source reports ready. Until then the old source stays in use and the request waits. The idle-enable bit matters only at the instant the sleep strobe fires. When it is set, the CPU clock stops and the peripherals keep running. When it is clear, everything stops. A wake event returns the machine to the Run mode of the currently selected source.

Top module: `pmm_top`

## Requirements
- R1: After reset the block is in primary Run mode: modeCode = 1, srcOneHot = 3'b001, cpuClkEn = 1, perClkEn = 1.
- R2: Select value 2'b00 requests primary (srcOneHot bit 0), 2'b01 requests secondary (bit 1), and 2'b10 or 2'b11 request internal (bit 2). When the requested source's ready flag is high, srcOneHot shows the new source after the next rising clock edge.
- R3: While the requested source's ready flag is low, srcOneHot keeps the current source. The switch completes at the first rising edge at which that flag is sampled high.
- R4: In every Run mode cpuClkEn = 1, perClkEn = 1, and srcOneHot has exactly one bit set.
- R5: A sleep strobe sampled in Run mode with idleEn = 1 enters the Idle mode of the current source at that edge: cpuClkEn = 0, perClkEn = 1, and srcOneHot unchanged.
- R6: A sleep strobe sampled in Run mode with idleEn = 0 enters Sleep: cpuClkEn = 0, perClkEn = 0, srcOneHot = 0.
- R7: idleEn is sampled only together with the sleep strobe. Changing it at any other time leaves modeCode unchanged.
- R8: A wake event sampled in Idle or Sleep returns the block to Run at that edge. cpuClkEn rises one cycle after the wake is presented, and the Run source matches the select bits when that source is ready.
- R9: The sleep strobe has no effect in Idle or Sleep, and the wake event has no effect in Run. If both are present in Run, the strobe wins.
- R10: modeCode is 0 for Sleep, 1/2/3 for Run on primary/secondary/internal, and 4/5/6 for Idle on primary/secondary/internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleEn | input | 1 | Idle-enable control bit |
| srcSel | input | 2 | Clock-source select control bits |
| sleepStrobe | input | 1 | One-cycle pulse when the sleep instruction executes |
| wakeEvt | input | 1 | Wake request |
| priRdy | input | 1 | Primary source running |
| secRdy | input | 1 | Secondary source running |
| intRdy | input | 1 | Internal oscillator block running |
| srcOneHot | output | 3 | One-hot source select ({internal, secondary, primary}), zero in Sleep |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| modeCode | output | 3 | Current mode code |

## Verification
The assertions assume that the sleep strobe and the wake event are synchronous to clk and held for whole cycles. They also assume that ready flags may change on any cycle, even while a request is pending. The stimulus changes every input only just after a falling edge, so each input is stable at the rising edge. It sweeps every starting source against every select value and every ready pattern. It then goes through each sleep and idle entry and exit, with idle-enable toggled in between. A cycle model in the bench, built from the mode table, is compared with every output on every cycle.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int SRC_COUNT = 3;
  localparam int SEL_W     = 2;
  localparam int MODE_W    = 3;
  localparam int IDX_W     = $clog2(SRC_COUNT);

  localparam logic [MODE_W-1:0] CODE_SLEEP     = MODE_W'(0);
  localparam logic [MODE_W-1:0] CODE_RUN_BASE  = MODE_W'(1);
  localparam logic [MODE_W-1:0] CODE_IDLE_BASE = MODE_W'(4);

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cpuGate;  // CPU clock stopped
    logic allGate;  // every clock stopped, no source in use
  } ctlStrobe_t;

  // select bits to one-hot request; upper bit set means internal block
  function automatic logic [SRC_COUNT-1:0] decodeSel(input logic [SEL_W-1:0] sel);
    logic [SRC_COUNT-1:0] v;
    v = '0;
    if (sel[1])      v[2] = 1'b1;
    else if (sel[0]) v[1] = 1'b1;
    else             v[0] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pmm_modefsm.sv
module pmm_modefsm
  import pmm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleEn,
  input  logic       sleepStrobe,
  input  logic       wakeEvt,
  output ctlStrobe_t ctl
);
  pwrState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:   if (sleepStrobe) stateNext = idleEn ? ST_IDLE : ST_SLEEP;
      ST_IDLE:  if (wakeEvt)     stateNext = ST_RUN;
      ST_SLEEP: if (wakeEvt)     stateNext = ST_RUN;
      default:                   stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign ctl.cpuGate = (state != ST_RUN);
  assign ctl.allGate = (state == ST_SLEEP);

  a_r5_idle_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepStrobe && idleEn) |=> (state == ST_IDLE));
  a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepStrobe && !idleEn) |=> (state == ST_SLEEP));
  a_r8_wake_run: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN && wakeEvt) |=> (state == ST_RUN));
  a_r9_strobe_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN && !wakeEvt) |=> $stable(state));
  a_r9_wake_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !sleepStrobe) |=> (state == ST_RUN));
endmodule

// File: rtl/pmm_srcpath.sv
module pmm_srcpath
  import pmm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     srcSel,
  input  logic [SRC_COUNT-1:0] readyVec,
  input  ctlStrobe_t           ctl,
  output logic [SRC_COUNT-1:0] srcOneHot,
  output logic                 cpuClkEn,
  output logic                 perClkEn,
  output logic [MODE_W-1:0]    modeCode
);
  logic [SRC_COUNT-1:0] reqVec, targetReady, curSrc;
  logic [IDX_W-1:0]     srcIdx;
  logic                 canSwitch;

  assign reqVec = decodeSel(srcSel);

  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_rdy
    assign targetReady[i] = reqVec[i] & readyVec[i];
  end

  assign canSwitch = (|targetReady) && (reqVec != curSrc);

  always_ff @(posedge clk) begin
    if (!rstN)          curSrc <= SRC_COUNT'(1);
    else if (canSwitch) curSrc <= reqVec;
  end

  always_comb begin
    srcIdx = '0;
    for (int k = 0; k < SRC_COUNT; k++)
      if (curSrc[k]) srcIdx = IDX_W'(k);
  end

  always_comb begin
    if (ctl.allGate)      modeCode = CODE_SLEEP;
    else if (ctl.cpuGate) modeCode = CODE_IDLE_BASE + MODE_W'(srcIdx);
    else                  modeCode = CODE_RUN_BASE + MODE_W'(srcIdx);
  end

  assign srcOneHot = ctl.allGate ? '0 : curSrc;
  assign cpuClkEn  = !ctl.cpuGate;
  assign perClkEn  = !ctl.allGate;

  a_r4_single_source: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.allGate |-> ($countones(srcOneHot) == 1));
  a_r3_hold_unready: assert property (@(posedge clk) disable iff (!rstN)
    ((reqVec & readyVec) == '0) |=> $stable(curSrc));
  a_r2_switch_ready: assert property (@(posedge clk) disable iff (!rstN)
    ((reqVec & readyVec) != '0) |=> (curSrc == $past(reqVec)));
  a_r6_sleep_dark: assert property (@(posedge clk) disable iff (!rstN)
    ctl.allGate |-> (!cpuClkEn && !perClkEn && srcOneHot == '0));
endmodule

// File: rtl/pmm_top.sv
module pmm_top
  import pmm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idleEn,
  input  logic [1:0] srcSel,
  input  logic       sleepStrobe,
  input  logic       wakeEvt,
  input  logic       priRdy,
  input  logic       secRdy,
  input  logic       intRdy,
  output logic [2:0] srcOneHot,
  output logic       cpuClkEn,
  output logic       perClkEn,
  output logic [2:0] modeCode
);
  ctlStrobe_t ctl;

  pmm_modefsm u_fsm (
    .clk(clk), .rstN(rstN), .idleEn(idleEn),
    .sleepStrobe(sleepStrobe), .wakeEvt(wakeEvt), .ctl(ctl)
  );

  pmm_srcpath u_path (
    .clk(clk), .rstN(rstN), .srcSel(srcSel),
    .readyVec({intRdy, secRdy, priRdy}), .ctl(ctl),
    .srcOneHot(srcOneHot), .cpuClkEn(cpuClkEn),
    .perClkEn(perClkEn), .modeCode(modeCode)
  );

  a_r10_code_range: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode <= 3'd6) && ((modeCode == 3'd0) == !perClkEn));
  a_r8_cpu_follows_code: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn == (modeCode >= 3'd1 && modeCode <= 3'd3));
endmodule

// File: tb/sim_pmm_top.sv
module sim_pmm_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleEn = 1'b0, sleepStrobe = 1'b0, wakeEvt = 1'b0;
  logic [1:0] srcSel = 2'b00;
  logic priRdy = 1'b1, secRdy = 1'b1, intRdy = 1'b1;
  logic [2:0] srcOneHot, modeCode;
  logic cpuClkEn, perClkEn;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  pmm_top u0 (.*);

  // cycle model built from the mode table: state 0 run, 1 idle, 2 sleep
  int mState = 0, mSrc = 0;
  function automatic int selIdx(input logic [1:0] s);
    return s[1] ? 2 : (s[0] ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState <= 0; mSrc <= 0;
    end else begin
      if (selIdx(srcSel) != mSrc && ({intRdy, secRdy, priRdy} >> selIdx(srcSel)) & 3'b001)
        mSrc <= selIdx(srcSel);
      if (mState == 0 && sleepStrobe) mState <= idleEn ? 1 : 2;
      else if (mState != 0 && wakeEvt) mState <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R4, R5, R6, R10)
  always @(negedge clk) begin
    if (rstN) begin
      int expCode;
      expCode = (mState == 2) ? 0 : (mState == 1 ? 4 + mSrc : 1 + mSrc);
      chk("R10 modeCode", modeCode, expCode);
      chk("R4 cpuClkEn", cpuClkEn, mState == 0);
      chk("R5 perClkEn", perClkEn, mState != 2);
      chk("R6 srcOneHot", srcOneHot, (mState == 2) ? 0 : (1 << mSrc));
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic goSource(input int idx);
    srcSel = 2'(idx); {intRdy, secRdy, priRdy} = 3'b111;
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    chk("R1 modeCode", modeCode, 1);
    chk("R1 srcOneHot", srcOneHot, 1);
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 perClkEn", perClkEn, 1);
    tick();

    // R2 / R3 sweep: start source x select value x ready pattern
    for (int from = 0; from < 3; from++)
      for (int sel = 0; sel < 4; sel++)
        for (int rdy = 0; rdy < 8; rdy++) begin
          int tgt;
          goSource(from);
          tgt = (sel >= 2) ? 2 : sel;
          srcSel = 2'(sel); {intRdy, secRdy, priRdy} = 3'(rdy);
          tick();
          chk(((rdy >> tgt) & 1) ? "R2 switch" : "R3 hold", srcOneHot,
              ((rdy >> tgt) & 1) ? (1 << tgt) : (1 << from));
          {intRdy, secRdy, priRdy} = 3'b111;
          tick();
          chk("R3 late switch", srcOneHot, 1 << tgt);
        end

    // idle / sleep entry and exit for every source
    for (int s = 0; s < 3; s++)
      for (int ie = 0; ie < 2; ie++) begin
        goSource(s);
        idleEn = ie[0]; sleepStrobe = 1'b1;
        tick();
        sleepStrobe = 1'b0;
        chk(ie ? "R5 idle code" : "R6 sleep code", modeCode, ie ? 4 + s : 0);
        idleEn = ~idleEn;
        tick();
        chk("R7 idleEn ignored", modeCode, ie ? 4 + s : 0);
        sleepStrobe = 1'b1;
        tick();
        sleepStrobe = 1'b0;
        chk("R9 strobe ignored", modeCode, ie ? 4 + s : 0);
        wakeEvt = 1'b1;
        chk("R8 cpu still off", cpuClkEn, 0);
        tick();
        wakeEvt = 1'b0;
        chk("R8 cpu resumed", cpuClkEn, 1);
        chk("R8 run code", modeCode, 1 + s);
      end

    // R9: wake in Run ignored; strobe and wake together in Run -> strobe wins
    goSource(0);
    wakeEvt = 1'b1;
    tick();
    wakeEvt = 1'b0;
    chk("R9 wake ignored", modeCode, 1);
    idleEn = 1'b0; sleepStrobe = 1'b1; wakeEvt = 1'b1;
    tick();
    sleepStrobe = 1'b0; wakeEvt = 1'b0;
    chk("R9 strobe wins", modeCode, 0);

    // R8 with select changed during Sleep, target not ready then ready
    srcSel = 2'b01; secRdy = 1'b0;
    tick();
    wakeEvt = 1'b1;
    tick();
    wakeEvt = 1'b0;
    chk("R8 wake keeps old source", modeCode, 1);
    secRdy = 1'b1;
    tick();
    chk("R8 pending switch done", modeCode, 2);

    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule